// File: doc/BRIEF.md
# Interval-Sampled Event Counter

This block counts single-cycle events on an input strobe and takes periodic snapshots of the running count. A programmable divider derives an interval tick from the system clock. On every tick the count is copied into a holding register and pushed into a small sample queue. A registered pulse then tells the interrupt logic that an interval has elapsed.

A mode register turns interval sampling on and off. It can also make each tick clear the counter, so that every sample holds the number of events in one interval rather than a running total. A register port lets software set the mode and the divider, and read the count, the last sample, the queue fill level, the fixed queue capacity and a sticky overflow flag. Software drains the queue through a separate pop interface. A second registered pulse reports each change of the count value.

Register map (word addresses on `reg_addr_i`): 0 mode, 1 divider, 2 live count, 3 last sample, 4 fill level, 5 capacity, 6 status. Read data is combinational and zero-extended. Addresses 7 and above read as 0.

Top module: `ivl_sample_counter`

## Requirements
- R1: With interval sampling enabled and a divider value d, a sample is taken once every d+1 clock cycles. A divider of 0 samples on every cycle. `tick_o` is high for one cycle just after each sample edge. The first sample after enabling is taken d+1 edges after the edge that writes the enable.
- R2: When mode bit 0 (address 0) is 0, no sample is taken, `tick_o` stays low and the queue fill level does not change.
- R3: When a sample arrives and the queue is full, the sample is dropped, the fill level stays at the capacity, and status bit 0 (address 6) is set. The bit stays set until software writes 1 to status bit 0.
- R4: At each sample edge, the last-sample register (address 3) takes the count as it stood before that edge. The queue entry pushed on that edge carries the same value.
- R5: When mode bit 1 is set, the count reads 0 after each sample edge. An increment that arrives on the sample edge itself is lost, and the value sampled is the count before the clear.
- R6: `chg_o` is high for exactly one cycle after each clock edge on which the count value changed. A clear from 0 to 0 does not raise it.
- R7: Address 4 reads the number of samples held in the queue. Address 5 reads the queue capacity, DEPTH.
- R8: The divider phase starts from zero on the edge that writes the divider register (address 1), and also whenever sampling is disabled. The first tick after either event comes d+1 edges later.
- R9: After reset the count, the mode, the divider, the last sample, the fill level, the overflow flag, `tick_o`, `chg_o` and `pop_valid_o` are all 0.
- R10: `pop_valid_o` is high whenever the queue is not empty. `pop_data_o` shows the oldest sample, and `pop_i` removes it on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_inc_i | input | 1 | Event strobe; adds one to the count on each edge where it is high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data, combinational |
| pop_i | input | 1 | Removes the oldest queued sample |
| pop_valid_o | output | 1 | Queue holds at least one sample |
| pop_data_o | output | CNT_W | Oldest queued sample |
| tick_o | output | 1 | One-cycle pulse after each sample edge |
| chg_o | output | 1 | One-cycle pulse after each change of the count |

## Verification
The bench sweeps divider values and both mode settings. It reads the first two queued samples, which catches an off-by-one in the divider period and a clear that takes the value after the reset instead of before it. A divider of 0 combined with clear-on-sample must give a second sample of 0; a design that let the coinciding increment through would give 1. The bench rewrites the divider partway through a period and times the next tick, so a divider that kept its old phase would tick early. Overflow is checked after the queue has been flooded, which exposes a queue that overwrites or overcounts, and a flag that fails to stick or fails to clear on a write of 1.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_DIV   = 3'd1,
    REG_COUNT = 3'd2,
    REG_LAST  = 3'd3,
    REG_FILL  = 3'd4,
    REG_CAP   = 3'd5,
    REG_STAT  = 3'd6
  } isc_reg_e;
endpackage

// File: rtl/isc_divider.sv
module isc_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] phase_q;

  assign tick_o = en_i && (phase_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_q <= '0;
    else if (!en_i || restart_i) phase_q <= '0;
    else if (phase_q >= div_i)  phase_q <= '0;
    else                        phase_q <= phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/isc_counter.sv
module isc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             chg_o
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             chg_q;

  // clear wins over a coinciding increment
  always_comb begin
    if (clr_i)      count_d = '0;
    else if (inc_i) count_d = count_q + CNT_W'(1);
    else            count_d = count_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      chg_q   <= (count_d != count_q);
    end
  end

  assign count_o = count_q;
  assign chg_o   = chg_q;
endmodule

// File: rtl/isc_fifo.sv
module isc_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4,
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             pop_i,
  output logic [W-1:0]     rdata_o,
  output logic             valid_o,
  output logic             full_o,
  output logic [LVL_W-1:0] level_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PW-1:0]    wr_q, rd_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  assign full_o  = (level_q == LVL_W'(DEPTH));
  assign valid_o = (level_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + PW'(1);
      if (do_pop)  rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + PW'(1);
      case ({do_push, do_pop})
        2'b10:   level_q <= level_q + LVL_W'(1);
        2'b01:   level_q <= level_q - LVL_W'(1);
        default: level_q <= level_q;
      endcase
    end
  end
endmodule

// File: rtl/ivl_sample_counter.sv
module ivl_sample_counter
  import isc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 16,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cnt_inc_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              pop_i,
  output logic              pop_valid_o,
  output logic [CNT_W-1:0]  pop_data_o,
  output logic              tick_o,
  output logic              chg_o
);
  logic             mode_en, mode_rst, ovf_q, tick_q;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] count_q, last_q;
  logic [LVL_W-1:0] fill;
  logic             full, tick_int, div_wr, mode_wr, stat_wr;
  isc_reg_e         addr;
  logic             wdata_unused;

  assign addr         = isc_reg_e'(reg_addr_i);
  assign div_wr       = reg_we_i && (addr == REG_DIV);
  assign mode_wr      = reg_we_i && (addr == REG_MODE);
  assign stat_wr      = reg_we_i && (addr == REG_STAT);
  assign wdata_unused = ^reg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_en  <= 1'b0;
      mode_rst <= 1'b0;
      div_q    <= '0;
      last_q   <= '0;
      ovf_q    <= 1'b0;
      tick_q   <= 1'b0;
    end else begin
      if (mode_wr) begin
        mode_en  <= reg_wdata_i[0];
        mode_rst <= reg_wdata_i[1];
      end
      if (div_wr) div_q <= reg_wdata_i[DIV_W-1:0];
      if (tick_int) last_q <= count_q;
      // set beats clear
      if (tick_int && full)              ovf_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[0]) ovf_q <= 1'b0;
      tick_q <= tick_int;
    end
  end

  isc_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode_en),
    .restart_i(div_wr),
    .div_i    (div_q),
    .tick_o   (tick_int)
  );

  isc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (cnt_inc_i),
    .clr_i  (tick_int && mode_rst),
    .count_o(count_q),
    .chg_o  (chg_o)
  );

  isc_fifo #(.W(CNT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (tick_int),
    .wdata_i(count_q),
    .pop_i  (pop_i),
    .rdata_o(pop_data_o),
    .valid_o(pop_valid_o),
    .full_o (full),
    .level_o(fill)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      REG_MODE:  reg_rdata_o = DATA_W'({mode_rst, mode_en});
      REG_DIV:   reg_rdata_o = DATA_W'(div_q);
      REG_COUNT: reg_rdata_o = DATA_W'(count_q);
      REG_LAST:  reg_rdata_o = DATA_W'(last_q);
      REG_FILL:  reg_rdata_o = DATA_W'(fill);
      REG_CAP:   reg_rdata_o = DATA_W'(DEPTH);
      REG_STAT:  reg_rdata_o = DATA_W'(ovf_q);
      default:   reg_rdata_o = '0;
    endcase
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int CNT_W = 16,
  parameter int LVL_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_int,
  input logic             mode_en,
  input logic             mode_rst,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] last_q,
  input logic [LVL_W-1:0] fill,
  input logic             ovf_q,
  input logic             pop_i,
  input logic             pop_valid_o,
  input logic             tick_o,
  input logic             chg_o
);
  p_no_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_en |=> !tick_o);

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill == LVL_W'(DEPTH)) && tick_int && !pop_i |=> (fill == LVL_W'(DEPTH)) && ovf_q);

  p_last_sample_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_int |=> last_q == $past(count_q));

  p_clear_on_tick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_int && mode_rst |=> count_q == '0);

  p_change_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chg_o |-> count_q != $past(count_q));

  p_fill_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill <= LVL_W'(DEPTH));

  p_pop_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_valid_o == (fill != '0));
endmodule

bind ivl_sample_counter isc_checker #(
  .CNT_W(CNT_W), .LVL_W(LVL_W), .DEPTH(DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_int   (tick_int),
  .mode_en    (mode_en),
  .mode_rst   (mode_rst),
  .count_q    (count_q),
  .last_q     (last_q),
  .fill       (fill),
  .ovf_q      (ovf_q),
  .pop_i      (pop_i),
  .pop_valid_o(pop_valid_o),
  .tick_o     (tick_o),
  .chg_o      (chg_o)
);

// File: tb/ivl_sample_counter_bench.sv
`timescale 1ns/1ps
module ivl_sample_counter_bench;
  localparam int CNT_W = 16, DIV_W = 16, DEPTH = 4, DATA_W = 32;
  localparam int A_MODE = 0, A_DIV = 1, A_COUNT = 2, A_LAST = 3,
                 A_FILL = 4, A_CAP = 5, A_STAT = 6;
  // {divider, clear mode, first sample, second sample}
  localparam logic [31:0] VEC [6] = '{
    {8'd0, 8'd0, 8'd1, 8'd2},
    {8'd0, 8'd1, 8'd1, 8'd0},
    {8'd3, 8'd0, 8'd4, 8'd8},
    {8'd3, 8'd1, 8'd4, 8'd3},
    {8'd5, 8'd0, 8'd6, 8'd12},
    {8'd2, 8'd1, 8'd3, 8'd2}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cnt_inc = 1'b0, we = 1'b0, pop = 1'b0;
  logic [2:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, rdata;
  logic pop_valid, tick, chg;
  logic [CNT_W-1:0] pop_data;
  int checks = 0, errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  ivl_sample_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DEPTH(DEPTH), .DATA_W(DATA_W))
  u_ivl_sample_counter (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_inc_i(cnt_inc),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pop_i(pop), .pop_valid_o(pop_valid), .pop_data_o(pop_data),
    .tick_o(tick), .chg_o(chg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic do_reset;
    rst_ni = 1'b0; cnt_inc = 1'b0; we = 1'b0; pop = 1'b0;
    step(2);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n;
    @(negedge clk);
    do_reset();

    // R9 reset state
    rd(A_COUNT, rv); chk("R9 count", rv, 0);
    rd(A_MODE, rv);  chk("R9 mode", rv, 0);
    rd(A_DIV, rv);   chk("R9 divider", rv, 0);
    rd(A_LAST, rv);  chk("R9 last", rv, 0);
    rd(A_FILL, rv);  chk("R9 fill", rv, 0);
    rd(A_STAT, rv);  chk("R9 overflow", rv, 0);
    chk("R9 pop_valid", pop_valid, 0);
    chk("R9 tick", tick, 0);
    chk("R9 chg", chg, 0);
    rd(A_CAP, rv);   chk("R7 capacity", rv, DEPTH);

    // R6 change pulse
    cnt_inc = 1'b1; step(1); cnt_inc = 1'b0;
    chk("R6 chg high", chg, 1);
    rd(A_COUNT, rv); chk("R6 count", rv, 1);
    step(1);
    chk("R6 chg low", chg, 0);

    // R2 disabled: no ticks
    wr(A_MODE, 32'h2);
    cnt_inc = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (tick) n++; end
    cnt_inc = 1'b0;
    chk("R2 no ticks", n, 0);
    rd(A_FILL, rv); chk("R2 fill", rv, 0);

    // table walk: R1 R4 R5 R3 R7 R10
    foreach (VEC[v]) begin
      do_reset();
      wr(A_DIV, {24'd0, VEC[v][31:24]});
      cnt_inc = 1'b1;
      wr(A_MODE, {30'd0, VEC[v][16], 1'b1});
      step(40);
      wr(A_MODE, 0);
      cnt_inc = 1'b0;
      rd(A_FILL, rv); chk("R7 fill full", rv, DEPTH);
      rd(A_STAT, rv); chk("R3 overflow set", rv, 1);
      chk("R10 valid", pop_valid, 1);
      chk("R1/R4 first sample", pop_data, VEC[v][15:8]);
      pop = 1'b1; step(1); pop = 1'b0;
      chk("R5 second sample", pop_data, VEC[v][7:0]);
      pop = 1'b1; step(1); pop = 1'b0;
      rd(A_FILL, rv); chk("R10 fill after pops", rv, DEPTH - 2);
    end

    // R3 sticky then write-1 clear
    step(3);
    rd(A_STAT, rv); chk("R3 sticky", rv, 1);
    wr(A_STAT, 0);
    rd(A_STAT, rv); chk("R3 write 0 keeps", rv, 1);
    wr(A_STAT, 1);
    rd(A_STAT, rv); chk("R3 cleared", rv, 0);

    // R1/R4 period and last = queued value
    do_reset();
    wr(A_DIV, 3);
    cnt_inc = 1'b1;
    wr(A_MODE, 1);
    n = 0;
    while (!tick && n < 30) begin step(1); n++; end
    chk("R1 first tick delay", n, 4);
    rd(A_LAST, rv); chk("R4 last reg", rv, 4);
    chk("R4 queued equals last", pop_data, rv);
    n = 0;
    step(1);
    chk("R1 tick one cycle", tick, 0);
    n = 1;
    while (!tick && n < 30) begin step(1); n++; end
    chk("R1 period", n, 4);
    rd(A_LAST, rv); chk("R4 second last", rv, 8);

    // R8 divider rewrite restarts phase
    do_reset();
    wr(A_DIV, 7);
    wr(A_MODE, 1);
    step(2);
    wr(A_DIV, 7);
    n = 0;
    while (!tick && n < 30) begin step(1); n++; end
    chk("R8 restart after divider write", n, 8);

    finish_run();
  end
endmodule